// File: doc/BRIEF.md
# Shared-Counter Multi-Channel PWM Timer

This block is a register-mapped pulse-width modulation timer. One up-counter, slowed by a power-of-two prescaler, is shared by every compare channel. The counter runs from zero up to a programmable 16-bit modulo value and then wraps. Each channel compares the running count with its own compare value and drives one edge-aligned PWM output. The duty cycle is set per channel. The period and the prescale ratio are common to all channels.

Software uses a plain 32-bit write strobe and a combinational read port. While the counter is stopped, writes to the modulo and compare registers take effect at once. While it runs, those writes are held in a shadow copy and applied at the next period start. Software can poll the register until the new value reads back. A two-bit edge-level field in each channel selects normal polarity, inverted polarity or a forced-low output, and a change to it applies at once. Each channel also has a write-one-to-clear match flag.

Top module: `shared_pwm_timer`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero, the counter is stopped and every PWM output is low.
- R2: Offset 0x04 reads the channel count in bits 7:0. Offset 0x08 always reads zero, and writes to it have no effect.
- R3: The control register at 0x10 reads back bits 5:0 as written. Bits 4:3 set the clock mode: code 01 runs the counter, and codes 00, 10 and 11 hold the count.
- R4: While the counter runs, the count at 0x14 advances once every 2^PS clocks, where PS is control bits 2:0.
- R5: The count runs from 0 up to the active modulo value and then returns to 0. Any write to 0x14 clears the count to 0.
- R6: While the clock mode is 00, a write to the modulo register (0x18) or to a channel value register (0x24+8n) reads back as the new value in the next cycle. Only bits 15:0 are kept.
- R7: While the clock mode is not 00, such a write leaves the read-back value unchanged until the next wrap of the count. The new value then reads back.
- R8: With edge-level code 10 or 11 in channel control bits 3:2 (channel control at 0x20+8n), the output is high while the count is below the active compare value. Over one period this gives min(V, MOD+1)·2^PS high cycles.
- R9: With edge-level code 01, the output is the complement of the R8 waveform.
- R10: With edge-level code 00, the output is low. A change to the edge-level field applies from the next cycle and does not wait for a wrap.
- R11: Channel control bit 7 sets while the counter runs and the count equals the channel's compare value. Writing 1 to bit 7 clears it, and writing 0 leaves it unchanged.
- R12: Channel control bits 5:2 read back as written, while the counter is stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| pwm_out | output | 4 | One PWM output per channel |

## Verification
The bench uses the default build: four channels, a 16-bit count and a 3-bit prescaler. Four channels let the random phase pick any channel and show that one channel's flag and value are kept apart from its neighbours. The 3-bit prescaler field reaches divide ratios of 1, 2 and 4 in the duty measurements, which keeps each period short enough to count high cycles exactly over whole periods. The shadowed loads are tested with a slow prescale, so that a write lands well before the wrap and the old value can be seen before the new one appears.

// File: rtl/spwm_pkg.sv
// spwm_pkg: register offsets, field codes and helper functions shared by
// the PWM timer modules. Assumes an 8-bit byte-offset register space.
package spwm_pkg;

    localparam logic [7:0] OFS_INFO    = 8'h04;
    localparam logic [7:0] OFS_SPARE   = 8'h08;
    localparam logic [7:0] OFS_CTRL    = 8'h10;
    localparam logic [7:0] OFS_COUNT   = 8'h14;
    localparam logic [7:0] OFS_MODULO  = 8'h18;
    localparam logic [7:0] OFS_CH_BASE = 8'h20;
    localparam int         CH_STRIDE   = 8;

    // Channel control bit positions
    localparam int CFG_FLAG_BIT = 7;
    localparam int CFG_EDGE_BIT = 5;
    localparam int CFG_MODE_BIT = 4;
    localparam int CFG_LVL_LO   = 2;

    typedef enum logic [1:0] {
        CLK_OFF  = 2'b00,
        CLK_RUN  = 2'b01,
        CLK_RSV2 = 2'b10,
        CLK_RSV3 = 2'b11
    } clk_mode_e;

    typedef enum logic [1:0] {
        LVL_OFF  = 2'b00,
        LVL_INV  = 2'b01,
        LVL_NORM = 2'b10,
        LVL_RSV  = 2'b11
    } edge_lvl_e;

    function automatic logic [7:0] cfg_ofs(input int idx);
        return OFS_CH_BASE + 8'(idx * CH_STRIDE);
    endfunction

    function automatic logic [7:0] cmp_ofs(input int idx);
        return OFS_CH_BASE + 8'(idx * CH_STRIDE + 4);
    endfunction

endpackage

// File: rtl/spwm_prescale.sv
// spwm_prescale: makes a one-cycle count-enable pulse every 2^ps clocks
// while run is high. Assumes ps may change at any time; a change only
// shifts the phase of the next pulse. Divider restarts when run drops.
module spwm_prescale #(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [PS_W-1:0] ps,
    output logic            tick
);
    localparam int DIV_W = (1 << PS_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W:0]   one_hot;
    logic [DIV_W:0]   full_mask;
    logic [DIV_W-1:0] mask;

    assign one_hot   = {{DIV_W{1'b0}}, 1'b1} << ps;
    assign full_mask = one_hot - 1'b1;
    assign mask      = full_mask[DIV_W-1:0];
    assign tick      = run && ((div_q & mask) == mask);

    // Free-running divider, cleared while the counter is not running
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end
endmodule

// File: rtl/spwm_counter.sv
// spwm_counter: the shared period counter. Counts up on each tick and
// returns to zero after reaching modulo. Assumes clr (software write)
// has priority over counting. wrap marks the period boundary.
module spwm_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr,
    input  logic [CNT_W-1:0] modulo,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    assign wrap = tick && (cnt >= modulo);

    // Count register: clear, wrap to zero, or step by one
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (wrap) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/spwm_shadow.sv
// spwm_shadow: a double-buffered value. Writes go straight to the active
// copy when hold is low; otherwise they wait in a pending copy that is
// moved across on load. Assumes load only pulses while hold is high.
module spwm_shadow #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         hold,
    input  logic         load,
    output logic [W-1:0] act
);
    logic [W-1:0] pend_q;

    // Pending and active copies
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            act    <= '0;
        end else begin
            if (wr) begin
                pend_q <= wdata;
            end
            if (wr && !hold) begin
                act <= wdata;
            end else if (load) begin
                act <= pend_q;
            end
        end
    end
endmodule

// File: rtl/spwm_channel.sv
// spwm_channel: one compare channel. Holds the channel control fields and
// a shadowed compare value, raises a match flag and drives an edge-aligned
// output. Assumes cnt never exceeds the active modulo while running.
module spwm_channel
    import spwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [7:0]       cfg_wdata,
    input  logic             val_wr,
    input  logic [CNT_W-1:0] val_wdata,
    input  logic             hold,
    input  logic             load,
    input  logic             run,
    input  logic [CNT_W-1:0] cnt,
    output logic [7:0]       cfg_rd,
    output logic [CNT_W-1:0] val_act,
    output logic             pwm
);
    edge_lvl_e lvl_q;
    logic      edge_q;
    logic      mode_q;
    logic      flag_q;
    logic      below;
    logic      match;
    logic      cfg_unused;

    assign cfg_unused = ^{cfg_wdata[6], cfg_wdata[1:0]};

    spwm_shadow #(.W(CNT_W)) u_val (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (val_wr),
        .wdata (val_wdata),
        .hold  (hold),
        .load  (load),
        .act   (val_act)
    );

    assign match = run && (cnt == val_act);
    assign below = cnt < val_act;

    // Control fields written directly by software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q  <= LVL_OFF;
            edge_q <= 1'b0;
            mode_q <= 1'b0;
        end else if (cfg_wr) begin
            lvl_q  <= edge_lvl_e'(cfg_wdata[CFG_LVL_LO+1:CFG_LVL_LO]);
            edge_q <= cfg_wdata[CFG_EDGE_BIT];
            mode_q <= cfg_wdata[CFG_MODE_BIT];
        end
    end

    // Match flag: set on compare hit, cleared by writing one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (match) begin
            flag_q <= 1'b1;
        end else if (cfg_wr && cfg_wdata[CFG_FLAG_BIT]) begin
            flag_q <= 1'b0;
        end
    end

    // Output level from the edge-level code
    always_comb begin
        case (lvl_q)
            LVL_OFF: pwm = 1'b0;
            LVL_INV: pwm = !below;
            default: pwm = below;
        endcase
    end

    assign cfg_rd = {flag_q, 1'b0, edge_q, mode_q, lvl_q, 2'b00};
endmodule

// File: rtl/shared_pwm_timer.sv
// shared_pwm_timer: top level. Decodes the register port, keeps the
// control register and the shadowed modulo, and instantiates the
// prescaler, the shared counter and NCH compare channels.
// Assumes ADDR_W >= 8, DATA_W > CNT_W and NCH <= 28.
module shared_pwm_timer
    import spwm_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int CNT_W  = 16,
    parameter int PS_W   = 3,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NCH-1:0]    pwm_out
);
    localparam int SC_W = PS_W + 3;

    logic [SC_W-1:0]           sc_q;
    logic [PS_W-1:0]           ps;
    clk_mode_e                 cmod;
    logic                      run;
    logic                      hold;
    logic                      tick;
    logic                      wrap;
    logic [CNT_W-1:0]          cnt_q;
    logic [CNT_W-1:0]          mod_act;
    logic                      sc_wr;
    logic                      cnt_wr;
    logic                      mod_wr;
    logic [NCH-1:0]            cfg_wr;
    logic [NCH-1:0]            val_wr;
    logic [NCH-1:0][7:0]       cfg_rd_all;
    logic [NCH-1:0][CNT_W-1:0] val_all;
    logic                      wdata_unused;

    assign wdata_unused = ^wdata[DATA_W-1:CNT_W];

    assign ps   = sc_q[PS_W-1:0];
    assign cmod = clk_mode_e'(sc_q[PS_W+1:PS_W]);
    assign run  = (cmod == CLK_RUN);
    assign hold = (cmod != CLK_OFF);

    assign sc_wr  = wr_en && (addr == ADDR_W'(OFS_CTRL));
    assign cnt_wr = wr_en && (addr == ADDR_W'(OFS_COUNT));
    assign mod_wr = wr_en && (addr == ADDR_W'(OFS_MODULO));

    // Status/control register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sc_q <= '0;
        end else if (sc_wr) begin
            sc_q <= wdata[SC_W-1:0];
        end
    end

    spwm_prescale #(.PS_W(PS_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .ps    (ps),
        .tick  (tick)
    );

    spwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .clr    (cnt_wr),
        .modulo (mod_act),
        .cnt    (cnt_q),
        .wrap   (wrap)
    );

    spwm_shadow #(.W(CNT_W)) u_mod (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (mod_wr),
        .wdata (wdata[CNT_W-1:0]),
        .hold  (hold),
        .load  (wrap),
        .act   (mod_act)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign cfg_wr[g] = wr_en && (addr == ADDR_W'(cfg_ofs(g)));
        assign val_wr[g] = wr_en && (addr == ADDR_W'(cmp_ofs(g)));

        spwm_channel #(.CNT_W(CNT_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_wr    (cfg_wr[g]),
            .cfg_wdata (wdata[7:0]),
            .val_wr    (val_wr[g]),
            .val_wdata (wdata[CNT_W-1:0]),
            .hold      (hold),
            .load      (wrap),
            .run       (run),
            .cnt       (cnt_q),
            .cfg_rd    (cfg_rd_all[g]),
            .val_act   (val_all[g]),
            .pwm       (pwm_out[g])
        );
    end

    // Read multiplexer; unmapped offsets read zero
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(OFS_INFO)) begin
            rdata = DATA_W'(NCH);
        end else if (addr == ADDR_W'(OFS_CTRL)) begin
            rdata = DATA_W'(sc_q);
        end else if (addr == ADDR_W'(OFS_COUNT)) begin
            rdata = DATA_W'(cnt_q);
        end else if (addr == ADDR_W'(OFS_MODULO)) begin
            rdata = DATA_W'(mod_act);
        end
        for (int i = 0; i < NCH; i++) begin
            if (addr == ADDR_W'(cfg_ofs(i))) begin
                rdata = DATA_W'(cfg_rd_all[i]);
            end
            if (addr == ADDR_W'(cmp_ofs(i))) begin
                rdata = DATA_W'(val_all[i]);
            end
        end
    end
endmodule

// File: rtl/spwm_checker.sv
// spwm_checker: concurrent properties for shared_pwm_timer, bound to it.
module spwm_checker
    import spwm_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   addr,
    input logic [DATA_W-1:0]   rdata,
    input logic [NCH-1:0]      pwm_out,
    input logic [1:0]          cmod,
    input logic [CNT_W-1:0]    cnt,
    input logic [CNT_W-1:0]    mod_act,
    input logic                wrap,
    input logic [NCH-1:0][7:0] cfg_all
);
    logic           cnt_wr;
    logic           mod_wr_now;
    logic [NCH-1:0] lvl_on;
    logic           cfg_unused;

    assign cfg_unused = ^cfg_all;
    assign cnt_wr     = wr_en && (addr == ADDR_W'(OFS_COUNT));
    assign mod_wr_now = wr_en && (addr == ADDR_W'(OFS_MODULO)) && (cmod == 2'b00);

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            lvl_on[i] = (cfg_all[i][CFG_LVL_LO+1:CFG_LVL_LO] != 2'b00);
        end
    end

    // R3
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmod != 2'b01 && !cnt_wr) |=> $stable(cnt))
        else $error("count moved while stopped");

    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmod == 2'b01 && !cnt_wr) |=>
        (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1 || cnt == '0))
        else $error("count made an illegal step");

    // R5
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !cnt_wr) |=> (cnt == '0))
        else $error("count not zero after wrap");

    // R7
    mod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrap && !mod_wr_now) |=> $stable(mod_act))
        else $error("active modulo changed outside a load point");

    // R10
    off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pwm_out & ~lvl_on) == '0))
        else $error("disabled channel output high");

    // R2
    param_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'(OFS_INFO)) |-> (rdata == DATA_W'(NCH)))
        else $error("channel count register wrong");
endmodule

bind shared_pwm_timer spwm_checker #(
    .NCH    (NCH),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .rdata   (rdata),
    .pwm_out (pwm_out),
    .cmod    (sc_q[PS_W+1:PS_W]),
    .cnt     (cnt_q),
    .mod_act (mod_act),
    .wrap    (wrap),
    .cfg_all (cfg_rd_all)
);

// File: tb/sim_shared_pwm_timer.sv
// sim_shared_pwm_timer: self-checking bench for shared_pwm_timer.
module sim_shared_pwm_timer;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;

    localparam logic [7:0] A_INFO = 8'h04;
    localparam logic [7:0] A_SPARE = 8'h08;
    localparam logic [7:0] A_SC = 8'h10;
    localparam logic [7:0] A_CNT = 8'h14;
    localparam logic [7:0] A_MOD = 8'h18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata;
    logic [NCH-1:0] pwm_out;

    int n_checks = 0;
    int n_err = 0;

    shared_pwm_timer u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .pwm_out (pwm_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [7:0] a_cfg(input int ch);
        return 8'(32 + 8 * ch);
    endfunction

    function automatic logic [7:0] a_val(input int ch);
        return 8'(36 + 8 * ch);
    endfunction

    // High cycles over one full period, from the duty requirements
    function automatic int exp_high(input int v, input int m, input int ps, input int lvl);
        int per;
        int on;
        int r;
        per = m + 1;
        on  = (v > m) ? per : v;
        case (lvl)
            0:       r = 0;
            1:       r = per - on;
            default: r = on;
        endcase
        return r << ps;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic count_high(input int ch, input int ncyc, output int hi);
        hi = 0;
        for (int k = 0; k < ncyc; k++) begin
            @(negedge clk);
            #1;
            if (pwm_out[ch]) hi++;
        end
    endtask

    task automatic setup_run(input int ch, input int m, input int v, input int ps, input int lvl);
        bus_wr(A_SC, 32'(ps));
        bus_wr(A_CNT, 32'h0);
        bus_wr(A_MOD, 32'(m));
        bus_wr(a_val(ch), 32'(v));
        bus_wr(a_cfg(ch), 32'h20 | 32'(lvl << 2));
        bus_wr(A_SC, 32'(ps) | 32'h8);
    endtask

    // Count changes of the counter over consecutive cycles
    task automatic count_changes(input int nsamp, output int changes, output int bad_wrap, input int m);
        logic [31:0] prev;
        changes  = 0;
        bad_wrap = 0;
        @(negedge clk);
        addr = A_CNT;
        #1;
        prev = rdata;
        for (int k = 1; k < nsamp; k++) begin
            @(negedge clk);
            #1;
            if (rdata != prev) changes++;
            if (rdata > 32'(m)) bad_wrap++;
            prev = rdata;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int hi;
        int ch_changes;
        int bad;
        int found;
        void'($urandom(32'd20240611));

        // Reset state (R1)
        repeat (4) @(negedge clk);
        #1;
        check("R1 outputs low in reset", 32'(pwm_out), 32'h0);
        rst_n = 1'b1;
        bus_rd(A_SC, d);   check("R1 control reset", d, 32'h0);
        bus_rd(A_MOD, d);  check("R1 modulo reset", d, 32'h0);
        bus_rd(A_CNT, d);  check("R1 count reset", d, 32'h0);
        bus_rd(a_cfg(0), d); check("R1 channel control reset", d, 32'h0);
        bus_rd(a_val(3), d); check("R1 channel value reset", d, 32'h0);
        check("R1 outputs low after reset", 32'(pwm_out), 32'h0);

        // Parameter and spare registers (R2)
        bus_rd(A_INFO, d); check("R2 channel count", d, 32'(NCH));
        bus_wr(A_SPARE, 32'hFFFF_FFFF);
        bus_rd(A_SPARE, d); check("R2 spare reads zero", d, 32'h0);

        // Immediate writes while stopped (R6), readback of control (R12)
        bus_wr(A_MOD, 32'hFFFF_0007);
        bus_rd(A_MOD, d); check("R6 modulo immediate, 16 bits kept", d, 32'h7);
        bus_wr(a_val(3), 32'h0000_BEEF);
        bus_rd(a_val(3), d); check("R6 value immediate", d, 32'hBEEF);
        bus_wr(a_cfg(0), 32'h34);
        bus_rd(a_cfg(0), d); check("R12 control fields readback", d, 32'h34);

        // Wrap sequence with PS=0 (R5)
        setup_run(0, 5, 3, 0, 2);
        count_changes(13, ch_changes, bad, 5);
        check("R5 count never above modulo", 32'(bad), 32'h0);
        check("R5 count changes every cycle at PS=0", 32'(ch_changes), 32'd12);

        // Prescaler rates (R4)
        setup_run(0, 100, 3, 1, 2);
        count_changes(17, ch_changes, bad, 100);
        check("R4 PS=1 advance rate", 32'(ch_changes), 32'd8);
        setup_run(0, 100, 3, 2, 2);
        count_changes(17, ch_changes, bad, 100);
        check("R4 PS=2 advance rate", 32'(ch_changes), 32'd4);

        // Clock mode 10 holds count, control readback (R3), count clear (R5)
        bus_wr(A_SC, 32'h12);
        bus_rd(A_SC, d); check("R3 control readback", d, 32'h12);
        bus_rd(A_CNT, d);
        repeat (5) @(negedge clk);
        begin
            logic [31:0] d2;
            bus_rd(A_CNT, d2);
            check("R3 mode 10 holds count", d2, d);
        end
        bus_wr(A_CNT, 32'h55);
        bus_rd(A_CNT, d); check("R5 count write clears", d, 32'h0);

        // Directed duty: normal, reserved, inverted, 0 and 100 percent (R8, R9)
        setup_run(1, 9, 4, 0, 2);
        count_high(1, 10, hi); check("R8 normal duty", 32'(hi), 32'(exp_high(4, 9, 0, 2)));
        setup_run(1, 9, 4, 0, 3);
        count_high(1, 10, hi); check("R8 reserved code acts normal", 32'(hi), 32'(exp_high(4, 9, 0, 3)));
        setup_run(1, 9, 4, 0, 1);
        count_high(1, 10, hi); check("R9 inverted duty", 32'(hi), 32'(exp_high(4, 9, 0, 1)));
        setup_run(2, 9, 0, 0, 2);
        count_high(2, 10, hi); check("R8 zero compare gives 0 percent", 32'(hi), 32'h0);
        setup_run(2, 9, 12, 0, 2);
        count_high(2, 10, hi); check("R8 compare above modulo gives 100 percent", 32'(hi), 32'd10);

        // Edge-level changes act at once (R10)
        setup_run(0, 9, 5, 0, 2);
        bus_wr(a_cfg(0), 32'h20);
        count_high(0, 10, hi); check("R10 code 00 forces low at once", 32'(hi), 32'h0);
        bus_wr(a_cfg(0), 32'h24);
        count_high(0, 10, hi); check("R10 code 01 applies at once", 32'(hi), 32'd5);

        // Buffered writes while running (R7)
        setup_run(0, 9, 3, 2, 2);
        found = 0;
        for (int k = 0; k < 100 && found == 0; k++) begin
            bus_rd(A_CNT, d);
            if (d == 32'd2) found = 1;
        end
        bus_wr(A_MOD, 32'd19);
        bus_rd(A_MOD, d); check("R7 modulo held until wrap", d, 32'd9);
        found = 0;
        for (int k = 0; k < 100 && found == 0; k++) begin
            bus_rd(A_MOD, d);
            if (d == 32'd19) found = 1;
        end
        check("R7 modulo applied at wrap", 32'(found), 32'h1);
        bus_wr(a_val(0), 32'd7);
        bus_rd(a_val(0), d); check("R7 value held until wrap", d, 32'd3);
        found = 0;
        for (int k = 0; k < 200 && found == 0; k++) begin
            bus_rd(a_val(0), d);
            if (d == 32'd7) found = 1;
        end
        check("R7 value applied at wrap", 32'(found), 32'h1);
        count_high(0, 80, hi); check("R7 new period and duty", 32'(hi), 32'(exp_high(7, 19, 2, 2)));

        // Match flag (R11)
        bus_wr(A_SC, 32'h0);
        bus_wr(A_CNT, 32'h0);
        bus_wr(A_MOD, 32'd9);
        bus_wr(a_val(1), 32'd5);
        bus_wr(a_cfg(1), 32'hA8);
        bus_wr(a_val(2), 32'd30);
        bus_wr(a_cfg(2), 32'hA8);
        bus_wr(A_SC, 32'h8);
        repeat (25) @(negedge clk);
        bus_wr(A_SC, 32'h0);
        bus_rd(a_cfg(1), d); check("R11 flag set on match", d, 32'hA8);
        bus_rd(a_cfg(2), d); check("R11 flag clear without match", d, 32'h28);
        bus_wr(a_cfg(1), 32'h28);
        bus_rd(a_cfg(1), d); check("R11 writing 0 keeps flag", d, 32'hA8);
        bus_wr(a_cfg(1), 32'hA8);
        bus_rd(a_cfg(1), d); check("R11 writing 1 clears flag", d, 32'h28);

        // Random duty patterns (R8, R9, R10, R4)
        for (int it = 0; it < 24; it++) begin
            int ch;
            int m;
            int v;
            int ps;
            int lvl;
            ch  = int'($urandom_range(NCH - 1, 0));
            m   = int'($urandom_range(15, 1));
            v   = int'($urandom_range(18, 0));
            ps  = int'($urandom_range(2, 0));
            lvl = int'($urandom_range(3, 0));
            setup_run(ch, m, v, ps, lvl);
            count_high(ch, (m + 1) << ps, hi);
            check("R8 R9 R10 random duty", 32'(hi), 32'(exp_high(v, m, ps, lvl)));
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule